// File: doc/BRIEF.md
# Synchronous Transmit Handshake Sequencer

This block runs the request-to-send / clear-to-send handshake for a synchronous serial transmitter and shifts each frame out. It works in the core clock domain. It samples an incoming transmit bit clock and acts only on that clock's falling edges. When the transmit FIFO reports data and the transmitter is enabled, the block asserts RTS on the next falling edge. It then waits for clear-to-send, if required, and sends an opening pattern ahead of the frame bytes. Each byte is taken from the FIFO's show-ahead output with a one-cycle pop pulse.

A frame ends with the byte marked last. On the falling edge after that byte's final bit, RTS is released and TXD goes back to idle. If the FIFO runs dry in the middle of a frame, the block fills the gap with further copies of the opening pattern. A clear-to-send bypass select makes the block ignore the CTS pin. Like the rest of the handshake setup, that select is taken in only while the transmitter is disabled. Dropping the enable aborts the frame at once.

Top module: `rts_cts_seq`

## Requirements
- R1: While reset is asserted and after its release, rts_n is 1, txd is 1 and fifo_pop is 0 until the first falling edge of tx_clk that finds data.
- R2: With tx_en high, rts_n goes low (asserted) on the first tx_clk falling edge at which fifo_valid is 1. A falling edge is a core cycle where tx_clk was 1 in the previous cycle and is 0 now.
- R3: If clear-to-send is granted at that same edge, the first pattern bit appears on txd at that same edge, so there are zero bit times between RTS assertion and the first bit. Clear-to-send is granted when the CTS pin, taken through a two-flop synchronizer, is low (active-low), or when the bypass is latched.
- R4: If clear-to-send is not granted, rts_n stays low and txd stays 1. The pattern starts at the first later falling edge where it is granted.
- R5: With the bypass latched, clear-to-send counts as granted whatever the level of cts_n.
- R6: cts_bypass is captured only while tx_en is 0. Changing it while the transmitter is enabled has no effect until the transmitter is disabled and re-enabled.
- R7: Every frame begins with the full 8-bit pattern PAT (default 8'h7E), sent MSB first. Frame bytes follow, also MSB first, one bit per falling edge. fifo_pop is high for one cycle on each edge that loads a byte.
- R8: On the falling edge after the last bit of a byte marked fifo_last, rts_n goes to 1 and txd goes to 1.
- R9: If fifo_valid is 0 when a byte is due inside a frame, another full pattern is sent instead, and the frame then resumes.
- R10: tx_en low forces rts_n and txd to 1 by the next core cycle, with no pop. A byte in flight is discarded, and the next frame starts again with the pattern.
- R11: txd is 1 whenever rts_n is 1. After a frame ends, a following frame asserts rts_n again on the next falling edge that finds data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable; low aborts and allows configuration capture |
| tx_clk | input | 1 | Transmit bit clock, sampled in the core domain |
| cts_n | input | 1 | Clear-to-send pin, active-low, asynchronous |
| cts_bypass | input | 1 | Treat clear-to-send as always granted (captured while disabled) |
| fifo_valid | input | 1 | Transmit FIFO not empty |
| fifo_data | input | 8 | Head byte of the FIFO (show-ahead) |
| fifo_last | input | 1 | Head byte is the last of its frame |
| fifo_pop | output | 1 | Removes the head byte this cycle |
| rts_n | output | 1 | Request-to-send, active-low |
| txd | output | 1 | Serial data out, idles high |

## Verification
The bench goes after the zero-delay start. If RTS were asserted one bit before the first pattern bit, every txd comparison in the first frame would be off by one bit. It also holds CTS off long enough to show that a design that ignored the synchronized CTS would start shifting early. It changes the bypass select while enabled, which catches a design that skips the disable-and-re-enable latch. It starves the FIFO in the middle of a frame to show filler patterns instead of stale data or an early RTS release. It drops the enable in the middle of a byte and checks that the next frame restarts with the pattern rather than the rest of the aborted byte. Back-to-back frames show RTS going high for exactly one bit before it is asserted again.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SYNC = 2'd2,
    ST_DATA = 2'd3
  } hs_state_t;
endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end
endmodule

// File: rtl/hs_edge.sv
module hs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tclk,
  output logic fall
);
  logic tclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tclk_q <= 1'b0;
    else        tclk_q <= tclk;
  end

  assign fall = tclk_q & ~tclk;
endmodule

// File: rtl/hs_fsm.sv
module hs_fsm
  import hs_pkg::*;
#(
  parameter int          W   = 8,
  parameter logic [W-1:0] PAT = 8'h7E,
  localparam int         IW  = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_en,
  input  logic         fall,
  input  logic         cts_n_s,
  input  logic         cts_bypass,
  input  logic         fifo_valid,
  input  logic [W-1:0] fifo_data,
  input  logic         fifo_last,
  output logic         fifo_pop,
  output logic         rts_n,
  output logic         txd
);
  localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

  hs_state_t    st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [W-1:0] sh_q, sh_d;
  logic         last_q, last_d;
  logic         rts_d, txd_d;
  logic         byp_q;
  logic         cts_ok;

  assign cts_ok = byp_q | ~cts_n_s;

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    sh_d     = sh_q;
    last_d   = last_q;
    rts_d    = rts_n;
    txd_d    = txd;
    fifo_pop = 1'b0;
    if (!tx_en) begin
      st_d  = ST_IDLE;
      rts_d = 1'b1;
      txd_d = 1'b1;
      idx_d = '0;
    end else if (fall) begin
      unique case (st_q)
        ST_IDLE: begin
          if (fifo_valid) begin
            rts_d = 1'b0;
            if (cts_ok) begin
              st_d  = ST_SYNC;
              txd_d = PAT[W-1];
              idx_d = TOP_IDX;
            end else begin
              st_d = ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (cts_ok) begin
            st_d  = ST_SYNC;
            txd_d = PAT[W-1];
            idx_d = TOP_IDX;
          end
        end
        default: begin
          if (idx_q != '0) begin
            idx_d = idx_q - 1'b1;
            txd_d = (st_q == ST_SYNC) ? PAT[idx_d] : sh_q[idx_d];
          end else if (st_q == ST_DATA && last_q) begin
            st_d  = ST_IDLE;
            rts_d = 1'b1;
            txd_d = 1'b1;
          end else if (fifo_valid) begin
            fifo_pop = 1'b1;
            st_d     = ST_DATA;
            sh_d     = fifo_data;
            last_d   = fifo_last;
            txd_d    = fifo_data[W-1];
            idx_d    = TOP_IDX;
          end else begin
            st_d  = ST_SYNC;
            txd_d = PAT[W-1];
            idx_d = TOP_IDX;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      sh_q   <= '0;
      last_q <= 1'b0;
      rts_n  <= 1'b1;
      txd    <= 1'b1;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      last_q <= last_d;
      rts_n  <= rts_d;
      txd    <= txd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      byp_q <= 1'b0;
    else if (!tx_en) byp_q <= cts_bypass;
  end

  p_rts_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts_n) |-> $past(fall && fifo_valid && tx_en));

  p_idle_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rts_n |-> txd);

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (rts_n && txd));

  p_pop_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !rts_n);

  p_bit_on_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(fall || !tx_en));

  p_release_on_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_n) |-> $past(fall || !tx_en));
endmodule

// File: rtl/rts_cts_seq.sv
module rts_cts_seq #(
  parameter int          W   = 8,
  parameter logic [W-1:0] PAT = 8'h7E
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_en,
  input  logic         tx_clk,
  input  logic         cts_n,
  input  logic         cts_bypass,
  input  logic         fifo_valid,
  input  logic [W-1:0] fifo_data,
  input  logic         fifo_last,
  output logic         fifo_pop,
  output logic         rts_n,
  output logic         txd
);
  logic fall;
  logic cts_n_s;

  hs_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .tclk (tx_clk),
    .fall (fall)
  );

  hs_sync2 #(.RST_VAL(1'b1)) u_cts (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (cts_n),
    .q    (cts_n_s)
  );

  hs_fsm #(.W(W), .PAT(PAT)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .fall      (fall),
    .cts_n_s   (cts_n_s),
    .cts_bypass(cts_bypass),
    .fifo_valid(fifo_valid),
    .fifo_data (fifo_data),
    .fifo_last (fifo_last),
    .fifo_pop  (fifo_pop),
    .rts_n     (rts_n),
    .txd       (txd)
  );
endmodule

// File: tb/sim_rts_cts_seq.sv
`timescale 1ns/100ps
module sim_rts_cts_seq;
  localparam logic [7:0] PATB = 8'h7E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic tx_clk = 1'b1;
  logic cts_n = 1'b1;
  logic cts_bypass = 1'b0;
  logic fifo_valid = 1'b0;
  logic [7:0] fifo_data = 8'h00;
  logic fifo_last = 1'b0;
  logic fifo_pop, rts_n, txd;

  rts_cts_seq u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_clk(tx_clk),
    .cts_n(cts_n), .cts_bypass(cts_bypass), .fifo_valid(fifo_valid),
    .fifo_data(fifo_data), .fifo_last(fifo_last), .fifo_pop(fifo_pop),
    .rts_n(rts_n), .txd(txd)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  logic [8:0] q[$];
  logic [8:0] pend[$];
  bit s_pop = 0;

  // reference model state (value expected after the coming edge)
  int m_st = 0;             // 0 idle, 1 wait for clear, 2 sending
  bit m_rts = 1, m_txd = 1, m_tprev = 0, m_c1 = 1, m_c2 = 1, m_byp = 0;
  bit m_last = 0, m_isdata = 0;
  bit bits[$];

  task automatic chk(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic start_pat();
    bits.delete();
    for (int i = 7; i >= 0; i--) bits.push_back(PATB[i]);
    m_txd = bits.pop_front();
    m_st = 2;
    m_isdata = 0;
  endtask

  always @(negedge clk) begin
    bit fall, ok, ep;
    chk("rts_n", rts_n, m_rts);
    chk("txd", txd, m_txd);
    ep = 0;
    if (!rst_n) begin
      m_st = 0; m_rts = 1; m_txd = 1; m_tprev = 0;
      m_c1 = 1; m_c2 = 1; m_byp = 0; bits.delete();
    end else begin
      fall = m_tprev && !tx_clk;
      ok = m_byp || !m_c2;
      m_tprev = tx_clk;
      m_c2 = m_c1;
      m_c1 = cts_n;
      if (!tx_en) begin
        m_byp = cts_bypass;
        m_st = 0; m_rts = 1; m_txd = 1; bits.delete();
      end else if (fall) begin
        if (m_st == 0) begin
          if (fifo_valid) begin
            m_rts = 0;
            if (ok) start_pat(); else m_st = 1;
          end
        end else if (m_st == 1) begin
          if (ok) start_pat();
        end else begin
          if (bits.size() != 0) m_txd = bits.pop_front();
          else if (m_isdata && m_last) begin
            m_st = 0; m_rts = 1; m_txd = 1;
          end else if (fifo_valid) begin
            ep = 1;
            for (int i = 7; i >= 0; i--) bits.push_back(fifo_data[i]);
            m_txd = bits.pop_front();
            m_last = fifo_last;
            m_isdata = 1;
          end else start_pat();
        end
      end
    end
    chk("fifo_pop", fifo_pop, ep);
    s_pop = fifo_pop;
  end

  always @(posedge clk) begin
    if (s_pop && q.size() != 0) void'(q.pop_front());
    while (pend.size() != 0) q.push_back(pend.pop_front());
    #1;
    fifo_valid = (q.size() != 0);
    if (q.size() != 0) {fifo_last, fifo_data} = q[0];
    else {fifo_last, fifo_data} = 9'h0;
  end

  int tcnt = 0;
  always @(posedge clk) begin
    #1;
    tcnt++;
    if (tcnt == 4) begin
      tcnt = 0;
      tx_clk = ~tx_clk;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(logic [7:0] d, bit l);
    pend.push_back({l, d});
  endtask

  task automatic wait_done();
    int n = 0;
    step(2);
    while ((q.size() != 0 || pend.size() != 0 || m_st != 0) && n < 20000) begin
      step(1);
      n++;
    end
    step(10);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    errors++;
    $display("FAIL watchdog expired tag=%s actual=hung expected=done", tag);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    step(4);
    tag = "R1";
    chk("reset rts_n", rts_n, 1'b1);
    chk("reset txd", txd, 1'b1);
    chk("reset pop", fifo_pop, 1'b0);
    rst_n = 1'b1;
    step(6);
    chk("idle rts_n", rts_n, 1'b1);

    // R2 R3 R7 R8: clear-to-send already granted, two-byte frame
    tag = "R2 R3 R7 R8";
    cts_n = 1'b0;
    tx_en = 1'b1;
    step(5);
    push(8'hA5, 0);
    push(8'h3C, 1);
    wait_done();

    // R4: clear-to-send held off, then granted
    tag = "R4";
    cts_n = 1'b1;
    push(8'h0F, 1);
    step(80);
    chk("waiting rts_n", rts_n, 1'b0);
    chk("waiting txd", txd, 1'b1);
    cts_n = 1'b0;
    wait_done();

    // R9: FIFO runs dry inside a frame
    tag = "R9";
    push(8'h81, 0);
    while (q.size() != 0 || pend.size() != 0) step(1);
    step(100);
    push(8'hFE, 1);
    wait_done();

    // R11: back-to-back frames
    tag = "R11";
    push(8'h11, 1);
    push(8'h22, 1);
    push(8'hC3, 0);
    push(8'h5A, 1);
    wait_done();

    // R10: abort in the middle of a byte, then restart
    tag = "R10";
    push(8'hF0, 0);
    push(8'h96, 0);
    push(8'h69, 1);
    step(110);
    tx_en = 1'b0;
    step(2);
    chk("abort rts_n", rts_n, 1'b1);
    chk("abort txd", txd, 1'b1);
    step(6);
    tx_en = 1'b1;
    wait_done();

    // R6: bypass changed while enabled has no effect yet
    tag = "R6";
    cts_n = 1'b1;
    cts_bypass = 1'b1;
    push(8'h55, 1);
    step(80);
    chk("bypass not latched rts_n", rts_n, 1'b0);
    chk("bypass not latched txd", txd, 1'b1);
    tx_en = 1'b0;
    step(4);

    // R5: bypass latched, CTS pin ignored
    tag = "R5";
    tx_en = 1'b1;
    wait_done();
    push(8'hE7, 0);
    push(8'h18, 1);
    wait_done();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule